// File: doc/BRIEF.md
# Paged Address Extender With Shared Low Window

This block widens the 16-bit address of a small processor to a 20-bit physical address. The processor does not know about the extra bits. Software selects a 64 KB page by writing a 4-bit value to one I/O port number. That value becomes the high-order part of every later physical address. The processor's own 16-bit address passes through as the low-order part.

A shared low window can be enabled. Every access that falls inside it is classified into the region class `COMMON`, and the page bits are then forced to zero. All other accesses fall into the region class `PAGED`, which uses the stored page. Because of this, the routine that changes the page can sit in the shared window and keep running after the switch.

A parameter selects how the page is combined with the address:
- **Concatenate:** the page and the address form disjoint 64 KB banks.
- **Overlap:** the page is scaled by 4 KB and added to the address, so neighbouring pages overlap.

The page register is the only state. Its one transition is a load on a matching write strobe. Reset returns it to page zero.

Top module: `bank_extend_latch`

## Requirements
- R1: While reset is asserted, and after it, the page is 0, so a paged access to `A` yields physical address `0x0000_A`. In concatenate mode this means `{4'h0, A}`.
- R2: On a rising clock edge, if the write strobe is high and the port number equals `IO_PORT` (default `0x40`), the 4-bit write data is loaded as the page.
- R3: A write to any other port number leaves the page unchanged. A matching port number with the strobe low also leaves the page unchanged.
- R4: The physical address follows the CPU address without a register. A new page therefore appears on the first access after the loading edge.
- R5: In concatenate mode, a `PAGED` access yields `{page, cpu_addr}`. Bits 15:0 of the physical address always equal the CPU address.
- R6: With the shared window enabled, any CPU address below `0x1000` yields a physical address equal to the zero-extended CPU address, whatever the page.
- R7: CPU address `0x1000`, the first address above the shared window, is `PAGED` and uses the stored page.
- R8: In overlap mode, the physical address is `(page << 12) + cpu_addr`, truncated to 20 bits. So page 1 with address `0x2000` and page 2 with address `0x1000` both reach `0x03000`.
- R9: With the shared window disabled, every address, including those below `0x1000`, uses the stored page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr_stb | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number of the write |
| io_wdata | input | 4 | Page value carried by the write |
| cpu_addr | input | 16 | Address driven by the processor |
| phys_addr | output | 20 | Extended physical address |

## Verification
Some behaviours are checked by assertions on every cycle:
- the page register loads on a matching write (R2);
- the page register holds on any other write (R3);
- in concatenate mode, the low 16 bits of the physical address equal the CPU address (R5);
- with the window enabled, any address inside the shared window maps to itself (R6).

Other behaviours can only be shown by the bench's scenarios:
- the exact physical addresses in both combining modes;
- the boundary at `0x0FFF` and `0x1000`;
- the aliasing between overlapping pages;
- the same-cycle visibility of a new page right after its write;
- the fall back to page zero on a mid-run reset;
- the variant with the window disabled.

// File: rtl/bx_pkg.sv
`timescale 1ns/1ps
package bx_pkg;

    // Region class of one bus access
    typedef enum logic {
        REGION_PAGED  = 1'b0,
        REGION_COMMON = 1'b1
    } region_e;

endpackage

// File: rtl/bx_page_reg.sv
`timescale 1ns/1ps
module bx_page_reg #(
    parameter int PAGE_W  = 4,
    parameter int PORT_W  = 8,
    parameter logic [PORT_W-1:0] IO_PORT = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr_stb,
    input  logic [PORT_W-1:0] io_port,
    input  logic [PAGE_W-1:0] io_wdata,
    output logic [PAGE_W-1:0] page
);

    logic hit;

    always_comb begin
        hit = io_wr_stb && (io_port == IO_PORT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page <= '0;
        end else if (hit) begin
            page <= io_wdata;
        end
    end

    // R2
    page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_stb && io_port == IO_PORT) |=> (page == $past(io_wdata)));

    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr_stb && io_port == IO_PORT) |=> $stable(page));

endmodule

// File: rtl/bx_window_decode.sv
`timescale 1ns/1ps
module bx_window_decode
    import bx_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter bit COMMON_EN   = 1'b1,
    parameter int COMMON_SIZE = 4096
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    output region_e           region
);

    always_comb begin
        if (COMMON_EN && (32'(cpu_addr) < COMMON_SIZE)) begin
            region = REGION_COMMON;
        end else begin
            region = REGION_PAGED;
        end
    end

endmodule

// File: rtl/bx_addr_form.sv
`timescale 1ns/1ps
module bx_addr_form
    import bx_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 4,
    parameter bit OVERLAP   = 1'b0,
    parameter int OVL_SHIFT = 12,
    localparam int PHYS_W   = ADDR_W + PAGE_W
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [PAGE_W-1:0] page,
    input  region_e           region,
    output logic [PHYS_W-1:0] phys_addr
);

    logic [PAGE_W-1:0] eff_page;

    always_comb begin
        unique case (region)
            REGION_COMMON: eff_page = '0;
            REGION_PAGED:  eff_page = page;
            default:       eff_page = '0;
        endcase
    end

    generate
        if (OVERLAP) begin : g_overlap
            logic [PHYS_W-1:0] base;
            always_comb begin
                base      = PHYS_W'(eff_page) << OVL_SHIFT;
                phys_addr = base + PHYS_W'(cpu_addr);
            end
        end else begin : g_concat
            always_comb begin
                phys_addr = {eff_page, cpu_addr};
            end
        end
    endgenerate

endmodule

// File: rtl/bank_extend_latch.sv
`timescale 1ns/1ps
module bank_extend_latch
    import bx_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 4,
    parameter int PORT_W      = 8,
    parameter logic [PORT_W-1:0] IO_PORT = 8'h40,
    parameter bit COMMON_EN   = 1'b1,
    parameter int COMMON_SIZE = 4096,
    parameter bit OVERLAP     = 1'b0,
    parameter int OVL_SHIFT   = 12,
    localparam int PHYS_W     = ADDR_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr_stb,
    input  logic [PORT_W-1:0] io_port,
    input  logic [PAGE_W-1:0] io_wdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [PHYS_W-1:0] phys_addr
);

    logic [PAGE_W-1:0] page;
    region_e           region;

    bx_page_reg #(
        .PAGE_W  (PAGE_W),
        .PORT_W  (PORT_W),
        .IO_PORT (IO_PORT)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_wr_stb (io_wr_stb),
        .io_port   (io_port),
        .io_wdata  (io_wdata),
        .page      (page)
    );

    bx_window_decode #(
        .ADDR_W      (ADDR_W),
        .COMMON_EN   (COMMON_EN),
        .COMMON_SIZE (COMMON_SIZE)
    ) u_decode (
        .cpu_addr (cpu_addr),
        .region   (region)
    );

    bx_addr_form #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .OVERLAP   (OVERLAP),
        .OVL_SHIFT (OVL_SHIFT)
    ) u_form (
        .cpu_addr  (cpu_addr),
        .page      (page),
        .region    (region),
        .phys_addr (phys_addr)
    );

    generate
        if (COMMON_EN) begin : g_win_chk
            // R6
            common_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (32'(cpu_addr) < COMMON_SIZE) |-> (phys_addr == PHYS_W'(cpu_addr)));
        end
        if (!OVERLAP) begin : g_low_chk
            // R5
            low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
                phys_addr[ADDR_W-1:0] == cpu_addr);
        end
    endgenerate

endmodule

// File: tb/test_bank_extend_latch.sv
`timescale 1ns/1ps
module test_bank_extend_latch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr_stb = 1'b0;
    logic [7:0]  io_port = 8'h00;
    logic [3:0]  io_wdata = 4'h0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [19:0] phys_cat;
    logic [19:0] phys_ovl;
    logic [19:0] phys_nowin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          sel;
        logic [19:0] exp;
        string       tag;
    } item_t;

    item_t q[$];

    always #4 clk = ~clk;

    bank_extend_latch i_bank_extend_latch (
        .clk(clk), .rst_n(rst_n), .io_wr_stb(io_wr_stb), .io_port(io_port),
        .io_wdata(io_wdata), .cpu_addr(cpu_addr), .phys_addr(phys_cat)
    );

    bank_extend_latch #(.OVERLAP(1'b1)) i_bank_extend_latch_ovl (
        .clk(clk), .rst_n(rst_n), .io_wr_stb(io_wr_stb), .io_port(io_port),
        .io_wdata(io_wdata), .cpu_addr(cpu_addr), .phys_addr(phys_ovl)
    );

    bank_extend_latch #(.COMMON_EN(1'b0)) i_bank_extend_latch_nowin (
        .clk(clk), .rst_n(rst_n), .io_wr_stb(io_wr_stb), .io_port(io_port),
        .io_wdata(io_wdata), .cpu_addr(cpu_addr), .phys_addr(phys_nowin)
    );

    // Every task starts and ends at a falling edge.
    task automatic expect_at(input int sel, input logic [19:0] exp, input string tag);
        item_t it;
        it.sel = sel;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic write_page(input logic [7:0] port, input logic [3:0] data, input logic stb);
        io_wr_stb = stb;
        io_port   = port;
        io_wdata  = data;
        @(negedge clk);
        io_wr_stb = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Monitor: pops and compares in the middle of the low phase.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [19:0] act;
                it = q.pop_front();
                case (it.sel)
                    0:       act = phys_cat;
                    1:       act = phys_ovl;
                    default: act = phys_nowin;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s inst=%0d actual=%05h expected=%05h",
                             it.tag, it.sel, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step();
        step();
        // R1: reset state, page 0
        cpu_addr = 16'h2345;
        expect_at(0, 20'h02345, "R1");
        expect_at(1, 20'h02345, "R1");
        expect_at(2, 20'h02345, "R1");
        step();
        rst_n = 1'b1;
        step();

        // R2 / R4: load page 5, visible on first following access
        write_page(8'h40, 4'h5, 1'b1);
        cpu_addr = 16'h1234;
        expect_at(0, 20'h51234, "R2_R4_R5");
        expect_at(1, 20'h06234, "R8");
        expect_at(2, 20'h51234, "R2");
        step();

        // R6 / R9: shared window
        cpu_addr = 16'h0ABC;
        expect_at(0, 20'h00ABC, "R6");
        expect_at(1, 20'h00ABC, "R6");
        expect_at(2, 20'h50ABC, "R9");
        step();

        cpu_addr = 16'h0FFF;
        expect_at(0, 20'h00FFF, "R6");
        step();

        // R7: first address above the window
        cpu_addr = 16'h1000;
        expect_at(0, 20'h51000, "R7");
        expect_at(1, 20'h06000, "R7");
        step();

        // R3: other port, then strobe low
        write_page(8'h41, 4'h7, 1'b1);
        cpu_addr = 16'h8000;
        expect_at(0, 20'h58000, "R3");
        step();
        write_page(8'h40, 4'h9, 1'b0);
        cpu_addr = 16'h8000;
        expect_at(0, 20'h58000, "R3");
        expect_at(2, 20'h58000, "R3");
        step();

        // R5 / R8: top page, top address
        write_page(8'h40, 4'hF, 1'b1);
        cpu_addr = 16'hFFFF;
        expect_at(0, 20'hFFFFF, "R5");
        expect_at(1, 20'h1EFFF, "R8");
        expect_at(2, 20'hFFFFF, "R5");
        step();

        // R8: aliasing between overlapping pages
        write_page(8'h40, 4'h1, 1'b1);
        cpu_addr = 16'h2000;
        expect_at(1, 20'h03000, "R8");
        expect_at(0, 20'h12000, "R5");
        step();
        write_page(8'h40, 4'h2, 1'b1);
        cpu_addr = 16'h1000;
        expect_at(1, 20'h03000, "R8");
        expect_at(0, 20'h21000, "R4");
        step();

        // R1: reset mid-run returns to page 0
        rst_n = 1'b0;
        cpu_addr = 16'h3000;
        expect_at(0, 20'h03000, "R1");
        expect_at(1, 20'h03000, "R1");
        step();
        rst_n = 1'b1;
        step();
        step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule